// File: doc/BRIEF.md
# Sequential Register-Wrapped ALU

This block puts a clocked register shell around an 8-bit multi-function arithmetic unit. Both operands arrive over one shared 8-bit data bus. A load strobe writes the bus into one operand register, and a select bit picks which one. A separate run strobe evaluates the operation chosen by a 4-bit opcode. It captures the 16-bit result and seven status flags in one clock edge. The result is read back one byte at a time through an output select.

The committed result and flags stay frozen until the next run strobe. Changing the opcode or reloading operands in between has no visible effect. The carry-using operations take their carry input from the carry flag of the previous run. This lets multi-byte additions and rotations be chained across runs.

Top module: `seqalu_top`

## Requirements
- R1: While `rst` is high at a rising edge, both operands, both result bytes and all seven flags become 0, so `res` reads 0 for either value of `out_sel`.
- R2: At a rising edge with `load`=1, `din` is written into operand A when `load_sel`=0 or into operand B when `load_sel`=1, and the other operand is unchanged.
- R3: Operands hold when `load`=0. When `load` and `run` are high at the same edge, the run uses the operand values from before that load.
- R4: At a rising edge with `run`=1, the low byte X, the high byte Y and all flags are captured. Without `run` they hold, whatever `op`, `din` or `load` do.
- R5: `res` shows X when `out_sel`=0 and Y when `out_sel`=1, combinationally.
- R6: Opcodes 0 to 3 give X = A AND, OR, XOR, XNOR B. Opcode 4 gives {C,X}=A+B unsigned. Opcode 5 gives X=A+B with V set on two's-complement overflow. Opcode 7 gives {Y,X}=signed A*B. Opcode 8 gives {Y,X}=unsigned A*B. Opcode 9 gives X=A-B with C set when A<B. Y is 0 unless stated.
- R7: Opcode 6 gives {C,X}=A+B+Cin. Opcode 10 gives X = A rotated left by one. Opcode 11 rotates the 9-bit value {Cin,A} left, so C=A[7] and X={A[6:0],Cin}. Opcode 12 gives X=A>>1 with C=A[0]. Opcode 13 shifts right keeping A[7], with C=A[0]. Opcode 14 gives X=A<<1 with C=A[7] and V=A[7]^A[6]. Cin is the C flag captured by the previous run (0 after reset).
- R8: Opcode 15 treats {B,A} as four decimal digits, B[7:4] being the most significant. It gives {Y,X} = the binary value, computed as Σ digit·10^k even for digits above 9. C is set when any digit exceeds 9.
- R9: Z is set when X and Y are both 0. F (`flag_any`) is Z|C|V. P is set when X equals its bit reverse. Q is set when X, taken as unsigned, is prime. N is X[7] for opcodes 5, 13 and 14, Y[7] for opcode 7, and 0 for all other opcodes. C and V are 0 where no rule above sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Shared operand data bus |
| load | input | 1 | Operand write strobe |
| load_sel | input | 1 | 0 selects operand A, 1 selects operand B |
| op | input | 4 | Operation code |
| run | input | 1 | Commit strobe for result and flags |
| out_sel | input | 1 | 0 shows X, 1 shows Y on `res` |
| res | output | 8 | Selected result byte |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow / shifted-out bit |
| flag_v | output | 1 | Overflow flag |
| flag_any | output | 1 | OR of Z, C and V |
| flag_pal | output | 1 | X is a bit palindrome |
| flag_prime | output | 1 | X is prime |
| flag_neg | output | 1 | Sign of the signed result |

## Verification
The hardest case to reach from the ports is a run that shares its edge with an operand load, combined with a carry-in that depends on an earlier run. Together they decide whether the pre-load operands and the previous carry were really the ones used. The stimulus builds carry chains: back-to-back carry-using runs follow carry-producing ones. It also forces a fraction of the random runs to coincide with a load to either operand. The bench's own model keeps the committed carry and the old operands, so both effects are predicted without looking inside the design.

// File: rtl/seqalu_pkg.sv
package seqalu_pkg;
  localparam int DW  = 8;
  localparam int RW  = 2 * DW;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_AND, OP_OR, OP_XOR, OP_XNOR, OP_ADDU, OP_ADDS, OP_ADC, OP_MULS,
    OP_MULU, OP_SUBU, OP_ROL, OP_RCL, OP_SHR, OP_SAR, OP_SHL, OP_BCD
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic v;
    logic any;
    logic pal;
    logic prime;
    logic neg;
  } alu_flags_t;

  function automatic logic is_pal(input logic [DW-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DW / 2; i++)
      if (x[i] != x[DW-1-i]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic is_prime(input logic [DW-1:0] x);
    logic p;
    int   xv;
    xv = int'(x);
    p  = (xv >= 2);
    for (int d = 2; d <= (1 << (DW / 2)); d++)
      if ((d * d) <= xv && (xv % d) == 0) p = 1'b0;
    return p;
  endfunction

  // result bit RW is the invalid-digit indication
  function automatic logic [RW:0] bcd_to_bin(input logic [RW-1:0] digits);
    logic [RW-1:0] acc;
    logic          bad;
    logic [3:0]    nib;
    acc = '0;
    bad = 1'b0;
    for (int i = RW / 4 - 1; i >= 0; i--) begin
      nib = digits[i*4 +: 4];
      bad = bad | (nib > 4'd9);
      acc = acc * RW'(10) + RW'(nib);
    end
    return {bad, acc};
  endfunction
endpackage

// File: rtl/seqalu_operands.sv
module seqalu_operands
  import seqalu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load_a_ev,
  input  logic          load_b_ev,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (load_a_ev) a_q <= din;
      if (load_b_ev) b_q <= din;
    end
  end
endmodule

// File: rtl/seqalu_core.sv
module seqalu_core
  import seqalu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] x,
  output logic [DW-1:0] y,
  output alu_flags_t    flags
);
  logic [DW:0]   sum_u;
  logic [DW:0]   sum_c;
  logic [RW-1:0] prod_u;
  logic [RW-1:0] prod_s;
  logic [RW:0]   bcd;
  logic          c, v, n;

  always_comb begin
    sum_u  = {1'b0, a} + {1'b0, b};
    sum_c  = sum_u + {{DW{1'b0}}, cin};
    prod_u = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    prod_s = {{DW{a[DW-1]}}, a} * {{DW{b[DW-1]}}, b};
    bcd    = bcd_to_bin({b, a});
    x = '0;
    y = '0;
    c = 1'b0;
    v = 1'b0;
    n = 1'b0;
    case (op)
      OP_AND:  x = a & b;
      OP_OR:   x = a | b;
      OP_XOR:  x = a ^ b;
      OP_XNOR: x = ~(a ^ b);
      OP_ADDU: {c, x} = sum_u;
      OP_ADDS: begin
        x = sum_u[DW-1:0];
        v = (a[DW-1] == b[DW-1]) && (x[DW-1] != a[DW-1]);
        n = x[DW-1];
      end
      OP_ADC:  {c, x} = sum_c;
      OP_MULS: begin
        {y, x} = prod_s;
        n = y[DW-1];
      end
      OP_MULU: {y, x} = prod_u;
      OP_SUBU: begin
        x = a - b;
        c = (a < b);
      end
      OP_ROL:  x = {a[DW-2:0], a[DW-1]};
      OP_RCL:  begin
        x = {a[DW-2:0], cin};
        c = a[DW-1];
      end
      OP_SHR:  begin
        x = {1'b0, a[DW-1:1]};
        c = a[0];
      end
      OP_SAR:  begin
        x = {a[DW-1], a[DW-1:1]};
        c = a[0];
        n = x[DW-1];
      end
      OP_SHL:  begin
        x = {a[DW-2:0], 1'b0};
        c = a[DW-1];
        v = a[DW-1] ^ a[DW-2];
        n = x[DW-1];
      end
      default: begin
        {y, x} = bcd[RW-1:0];
        c = bcd[RW];
      end
    endcase
    flags.z     = ({y, x} == '0);
    flags.c     = c;
    flags.v     = v;
    flags.any   = flags.z | c | v;
    flags.pal   = is_pal(x);
    flags.prime = is_prime(x);
    flags.neg   = n;
  end
endmodule

// File: rtl/seqalu_results.sv
module seqalu_results
  import seqalu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          commit_ev,
  input  logic [DW-1:0] x_d,
  input  logic [DW-1:0] y_d,
  input  alu_flags_t    f_d,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output alu_flags_t    f_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
      f_q <= '0;
    end else if (commit_ev) begin
      x_q <= x_d;
      y_q <= y_d;
      f_q <= f_d;
    end
  end
endmodule

// File: rtl/seqalu_top.sv
module seqalu_top
  import seqalu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          load,
  input  logic          load_sel,
  input  logic [OPW-1:0] op,
  input  logic          run,
  input  logic          out_sel,
  output logic [DW-1:0] res,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v,
  output logic          flag_any,
  output logic          flag_pal,
  output logic          flag_prime,
  output logic          flag_neg
);
  logic          load_a_ev, load_b_ev, commit_ev;
  logic [DW-1:0] a_q, b_q, x_d, y_d, x_q, y_q;
  alu_flags_t    f_d, f_q;

  assign load_a_ev = load & ~load_sel;
  assign load_b_ev = load &  load_sel;
  assign commit_ev = run;

  seqalu_operands u_opnd (
    .clk(clk), .rst(rst), .load_a_ev(load_a_ev), .load_b_ev(load_b_ev),
    .din(din), .a_q(a_q), .b_q(b_q)
  );

  seqalu_core u_core (
    .op(alu_op_e'(op)), .a(a_q), .b(b_q), .cin(f_q.c),
    .x(x_d), .y(y_d), .flags(f_d)
  );

  seqalu_results u_res (
    .clk(clk), .rst(rst), .commit_ev(commit_ev),
    .x_d(x_d), .y_d(y_d), .f_d(f_d),
    .x_q(x_q), .y_q(y_q), .f_q(f_q)
  );

  assign res        = out_sel ? y_q : x_q;
  assign flag_z     = f_q.z;
  assign flag_c     = f_q.c;
  assign flag_v     = f_q.v;
  assign flag_any   = f_q.any;
  assign flag_pal   = f_q.pal;
  assign flag_prime = f_q.prime;
  assign flag_neg   = f_q.neg;
endmodule

// File: rtl/seqalu_chk.sv
module seqalu_chk
  import seqalu_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic [DW-1:0]  din,
  input logic           load,
  input logic           load_sel,
  input logic [OPW-1:0] op,
  input logic           run,
  input logic [DW-1:0]  a_q,
  input logic [DW-1:0]  b_q,
  input logic [DW-1:0]  x_q,
  input logic [DW-1:0]  y_q,
  input alu_flags_t     f_q
);
  logic          rst_d = 1'b0;
  logic [DW-1:0] adc_exp;

  assign adc_exp = a_q + b_q + {{(DW-1){1'b0}}, f_q.c};

  always @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      // R1
      reset_clear_chk: assert (a_q == '0 && b_q == '0 && x_q == '0 &&
                               y_q == '0 && f_q == '0);
    end
  end

  // R2
  load_a_chk: assert property (@(posedge clk) disable iff (rst)
    load && !load_sel |=> a_q == $past(din) && $stable(b_q));

  // R2
  load_b_chk: assert property (@(posedge clk) disable iff (rst)
    load && load_sel |=> b_q == $past(din) && $stable(a_q));

  // R3
  operand_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(a_q) && $stable(b_q));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(x_q) && $stable(y_q) && $stable(f_q));

  // R9
  any_flag_chk: assert property (@(posedge clk) disable iff (rst)
    f_q.any == (f_q.z | f_q.c | f_q.v));

  // R7
  carry_in_chk: assert property (@(posedge clk) disable iff (rst)
    run && op == OP_ADC |=> x_q == $past(adc_exp));
endmodule

bind seqalu_top seqalu_chk u_chk (
  .clk(clk), .rst(rst), .din(din), .load(load), .load_sel(load_sel),
  .op(op), .run(run), .a_q(a_q), .b_q(b_q), .x_q(x_q), .y_q(y_q), .f_q(f_q)
);

// File: tb/seqalu_top_bench.sv
module seqalu_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic       load = 1'b0, load_sel = 1'b0, run = 1'b0, out_sel = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] res;
  logic       flag_z, flag_c, flag_v, flag_any, flag_pal, flag_prime, flag_neg;

  int compared = 0, mismatched = 0;
  int ma = 0, mb = 0, mc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seqalu_top u_seqalu_top (
    .clk(clk), .rst(rst), .din(din), .load(load), .load_sel(load_sel),
    .op(op), .run(run), .out_sel(out_sel), .res(res), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .flag_any(flag_any),
    .flag_pal(flag_pal), .flag_prime(flag_prime), .flag_neg(flag_neg)
  );

  // expected committed state
  int ex = 0, ey = 0;
  bit ez = 0, ec = 0, ev = 0, ep = 0, eq = 0, en = 0;

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic bit pal_of(int v);
    bit ok = 1;
    for (int i = 0; i < 8; i++)
      if (((v >> i) & 1) != ((v >> (7 - i)) & 1)) ok = 0;
    return ok;
  endfunction

  function automatic bit prime_of(int v);
    int divs = 0;
    if (v < 2) return 0;
    for (int k = 2; k < v; k++) if (v % k == 0) divs++;
    return divs == 0;
  endfunction

  task automatic model(input int o, input int a, input int b, input int cin);
    int s, r, d3, d2, d1, d0;
    ex = 0; ey = 0; ec = 0; ev = 0; en = 0;
    case (o)
      0: ex = a & b;
      1: ex = a | b;
      2: ex = a ^ b;
      3: ex = 255 - (a ^ b);
      4: begin s = a + b; ex = s % 256; ec = s > 255; end
      5: begin
        ex = (a + b) % 256; s = sgn(a) + sgn(b);
        ev = (s > 127) || (s < -128); en = ex > 127;
      end
      6: begin s = a + b + cin; ex = s % 256; ec = s > 255; end
      7: begin
        s = sgn(a) * sgn(b); r = (s < 0) ? s + 65536 : s;
        ey = r / 256; ex = r % 256; en = ey > 127;
      end
      8: begin r = a * b; ey = r / 256; ex = r % 256; end
      9: begin ex = (a - b + 256) % 256; ec = a < b; end
      10: ex = (a * 2) % 256 + a / 128;
      11: begin ex = (a * 2) % 256 + cin; ec = a / 128; end
      12: begin ex = a / 2; ec = a % 2; end
      13: begin ex = a / 2 + ((a > 127) ? 128 : 0); ec = a % 2; en = ex > 127; end
      14: begin
        ex = (a * 2) % 256; ec = a > 127;
        ev = ((a / 128) % 2) != ((a / 64) % 2); en = ex > 127;
      end
      default: begin
        d3 = b / 16; d2 = b % 16; d1 = a / 16; d0 = a % 16;
        r = (d3 * 1000 + d2 * 100 + d1 * 10 + d0) % 65536;
        ey = r / 256; ex = r % 256;
        ec = (d3 > 9) || (d2 > 9) || (d1 > 9) || (d0 > 9);
      end
    endcase
    ez = (ex == 0) && (ey == 0);
    ep = pal_of(ex);
    eq = prime_of(ex);
  endtask

  task automatic cmp(input string req, input string what, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    out_sel = 1'b0; #1;
    cmp(req, "X", res, ex);
    cmp("R9", "Z", flag_z, ez);
    cmp(req, "C", flag_c, ec);
    cmp(req, "V", flag_v, ev);
    cmp("R9", "F", flag_any, ez | ec | ev);
    cmp("R9", "P", flag_pal, ep);
    cmp("R9", "Q", flag_prime, eq);
    cmp("R9", "N", flag_neg, en);
    out_sel = 1'b1; #1;
    cmp("R5", "Y", res, ey);
    out_sel = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input bit sel, input int v);
    din = v[7:0]; load = 1'b1; load_sel = sel;
    step();
    load = 1'b0;
    if (sel) mb = v; else ma = v;
  endtask

  task automatic go(input int o, input string req);
    op = o[3:0]; run = 1'b1;
    step();
    run = 1'b0;
    model(o, ma, mb, mc);
    mc = ec;
    check_all(req);
  endtask

  // run and load on the same edge (R3)
  task automatic go_load(input int o, input bit sel, input int v);
    op = o[3:0]; run = 1'b1; din = v[7:0]; load = 1'b1; load_sel = sel;
    step();
    run = 1'b0; load = 1'b0;
    model(o, ma, mb, mc);
    mc = ec;
    if (sel) mb = v; else ma = v;
    check_all("R3");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    rst = 1'b1;
    step(); step();
    // R1: reset state
    rst = 1'b0;
    model(0, 0, 0, 0); ex = 0; ey = 0; ez = 0; ec = 0; ev = 0; ep = 0; eq = 0; en = 0;
    out_sel = 1'b0; #1; cmp("R1", "X after reset", res, 0);
    out_sel = 1'b1; #1; cmp("R1", "Y after reset", res, 0);
    cmp("R1", "flags after reset",
        {flag_z, flag_c, flag_v, flag_any, flag_pal, flag_prime, flag_neg}, 0);
    out_sel = 1'b0;

    // R2: load A and B separately, observed through OR and SUBU
    put(0, 8'h5A); put(1, 8'h0F);
    go(1, "R2");
    put(1, 8'h60);
    go(9, "R2");
    // R6 corner cases
    put(0, 127); put(1, 1);   go(5, "R6");
    put(0, 128); put(1, 128); go(7, "R6");
    put(0, 255); put(1, 255); go(8, "R6");
    go(4, "R6");
    // R7 carry chain: carry from the add feeds ADC and RCL
    go(6, "R7");
    put(0, 8'h81); go(11, "R7");
    go(11, "R7");
    go(13, "R7"); go(14, "R7"); go(10, "R7"); go(12, "R7");
    // R8 decimal conversion, valid and invalid digits
    put(0, 8'h99); put(1, 8'h99); go(15, "R8");
    put(0, 8'h3A); put(1, 8'h01); go(15, "R8");
    // R9 palindrome / prime / zero
    put(0, 251); put(1, 0); go(1, "R9");
    put(0, 8'h81); go(0, "R9");
    // R4: no run -> results hold while op, operands change
    op = 4'd8; put(0, 8'h33); put(1, 8'h44); step();
    check_all("R4");
    // R3: load and run together
    put(0, 8'h10); put(1, 8'h20);
    go_load(4, 0, 8'hF0);
    go_load(9, 1, 8'hFF);
    go(4, "R3");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int o;
      int pick;
      pick = $urandom_range(0, 9);
      if (pick < 3) put(0, $urandom_range(0, 255));
      else if (pick < 5) put(1, $urandom_range(0, 255));
      o = (pick == 9) ? $urandom_range(4, 6) : $urandom_range(0, 15);
      if (pick == 8) go_load(o, $urandom_range(0, 1), $urandom_range(0, 255));
      else go(o, "R6");
    end

    // R1: reset in mid-operation
    rst = 1'b1; step(); rst = 1'b0; ma = 0; mb = 0; mc = 0;
    out_sel = 1'b0; #1; cmp("R1", "X after late reset", res, 0);
    cmp("R1", "C after late reset", flag_c, 0);
    go(6, "R1");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule